// File: doc/BRIEF.md
# Serial Flash Controller Interrupt Status and Mask Unit

This block collects one-cycle event pulses from a serial flash transfer engine and holds each as a sticky flag, so that software can find out later what happened during a command. The flags are: receive data ready, transmit data empty, transmitter idle, overrun, chip-select rise, chip-select fall and instruction end. A live "controller enabled" level is shown next to them. Software reads all of them through a status register. That read also clears the sticky flags, so stale events can be discarded before a new command starts.

An interrupt mask selects which flags drive the single level-sensitive interrupt line. Software never writes the mask directly. One write register sets mask bits and a second write register clears them, each on a write-one basis. A read-only mask register returns the current mask. A command-complete level is also provided. It is high once both the instruction-end flag and the chip-select-rise flag are held, because only that pair marks a finished command.

The register bus is a single-cycle request interface. Writes take effect at the request edge. Read data and its valid strobe appear one cycle after the request, driven by a two-state response machine: `BUS_IDLE` goes to `BUS_RESP` on a read request, `BUS_RESP` stays in `BUS_RESP` on a back-to-back read request, and otherwise it returns to `BUS_IDLE`.

Top module: `flash_irq_unit`

## Requirements
- R1: A synchronous reset clears every sticky flag and the whole mask, and drives `irq_o`, `cmd_done_o` and `bus_rvalid` low.
- R2: A one-cycle pulse on `evt_i[k]` sets a sticky status flag, which stays set without further pulses. The mapping from event index to status bit is: index 0 receive data ready to bit 0, index 1 transmit data empty to bit 1, index 2 transmitter idle to bit 2, index 3 overrun to bit 3, index 4 chip-select rise to bit 8, index 5 chip-select fall to bit 9, index 6 instruction end to bit 10.
- R3: A read of the status register (byte address 0x0) returns the flags on `bus_rdata` with `bus_rvalid` high exactly one cycle after the request, and clears all sticky flags.
- R4: An event that arrives in the same cycle as a clearing status read is absent from that read's data and remains set afterwards.
- R5: Status bit 24 always reflects the live level of `ctrl_en_i` at the read request, and a status read never clears it.
- R6: A write to the enable register (address 0x4) sets the mask bits where the write data is one and leaves the others unchanged. Only the seven sticky-flag positions hold mask bits; all other positions read zero.
- R7: A write to the disable register (address 0x8) clears the mask bits where the write data is one and leaves the others unchanged.
- R8: A read of the mask register (address 0xC) returns the current mask. Writes to the status or mask address change nothing. Reads of the enable or disable address return zero.
- R9: `irq_o` is high exactly while at least one sticky flag is set whose mask bit is also set.
- R10: `cmd_done_o` is high exactly while both the instruction-end flag (bit 10) and the chip-select-rise flag (bit 8) are set, whatever the order in which they arrived.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [3:2] pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | High one cycle after a read request |
| evt_i | input | 7 | Event pulses from the transfer engine |
| ctrl_en_i | input | 1 | Live controller-enabled level |
| irq_o | output | 1 | Level interrupt |
| cmd_done_o | output | 1 | Command-complete level |

## Verification
The bench sweeps all 128 mask subsets against paired event subsets. A wrong flag-to-bit mapping or a missing mask gate shows up there as a mismatched status word or a wrong interrupt level. It fires an event in the very cycle of a clearing read: a design that lets the clear win would lose that event, and one that samples after the set would report it early. It writes noisy data to unimplemented and read-only locations, which a loose decoder would turn into mask or flag changes. It delivers the completion pair in both orders, so a design that wants a fixed sequence or only one of the two flags raises the completion level at the wrong time.

// File: rtl/irqu_pkg.sv
package irqu_pkg;

    localparam int REG_W   = 32;
    localparam int NUM_EVT = 7;

    // status bit positions (software decodes these)
    localparam int POS_RXRDY   = 0;
    localparam int POS_TXEMPTY = 1;
    localparam int POS_TXIDLE  = 2;
    localparam int POS_OVERRUN = 3;
    localparam int POS_CSRISE  = 8;
    localparam int POS_CSFALL  = 9;
    localparam int POS_INSTEND = 10;
    localparam int POS_ENLIVE  = 24;

    typedef enum logic [1:0] {
        REG_STATUS  = 2'd0,
        REG_ENABLE  = 2'd1,
        REG_DISABLE = 2'd2,
        REG_MASK    = 2'd3
    } reg_sel_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    typedef struct packed {
        logic rd_status;
        logic rd_any;
        logic wr_enable;
        logic wr_disable;
    } bus_cmd_t;

    function automatic int evt_pos(input int idx);
        int p;
        unique case (idx)
            0:       p = POS_RXRDY;
            1:       p = POS_TXEMPTY;
            2:       p = POS_TXIDLE;
            3:       p = POS_OVERRUN;
            4:       p = POS_CSRISE;
            5:       p = POS_CSFALL;
            default: p = POS_INSTEND;
        endcase
        return p;
    endfunction

    function automatic logic [REG_W-1:0] evt_to_word(input logic [NUM_EVT-1:0] ev);
        logic [REG_W-1:0] w;
        w = '0;
        for (int i = 0; i < NUM_EVT; i++) begin
            w[evt_pos(i)] = ev[i];
        end
        return w;
    endfunction

    localparam logic [REG_W-1:0] STICKY_BITS = evt_to_word({NUM_EVT{1'b1}});

endpackage

// File: rtl/irqu_flags.sv
module irqu_flags
    import irqu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] set_word,
    input  logic             clr_all,
    output logic [REG_W-1:0] flags_q
);

    // a new event wins over a same-cycle clearing read
    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        if (STICKY_BITS[b]) begin : g_flop
            always_ff @(posedge clk) begin
                if (rst) begin
                    flags_q[b] <= 1'b0;
                end else if (set_word[b]) begin
                    flags_q[b] <= 1'b1;
                end else if (clr_all) begin
                    flags_q[b] <= 1'b0;
                end
            end
        end else begin : g_tie
            assign flags_q[b] = 1'b0;
        end
    end

endmodule

// File: rtl/irqu_mask.sv
module irqu_mask
    import irqu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] mask_q
);

    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        if (STICKY_BITS[b]) begin : g_flop
            always_ff @(posedge clk) begin
                if (rst) begin
                    mask_q[b] <= 1'b0;
                end else if (set_en && wdata[b]) begin
                    mask_q[b] <= 1'b1;
                end else if (clr_en && wdata[b]) begin
                    mask_q[b] <= 1'b0;
                end
            end
        end else begin : g_tie
            assign mask_q[b] = 1'b0;
        end
    end

endmodule

// File: rtl/irqu_bus.sv
module irqu_bus
    import irqu_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  status_word,
    input  logic [REG_W-1:0]  mask_word,
    output bus_cmd_t          cmd,
    output logic [REG_W-1:0]  rdata,
    output logic              rvalid
);

    localparam int REG_LSB = 2;
    localparam int WIN_LSB = REG_LSB + 2;

    bus_state_e       state_q, state_d;
    reg_sel_e         reg_sel;
    logic             in_window;
    logic [REG_W-1:0] rdata_q;

    assign reg_sel = reg_sel_e'(addr[WIN_LSB-1:REG_LSB]);

    if (ADDR_W > WIN_LSB) begin : g_win
        assign in_window = (addr[ADDR_W-1:WIN_LSB] == '0);
    end else begin : g_nowin
        assign in_window = 1'b1;
    end

    always_comb begin
        cmd            = '0;
        cmd.rd_any     = sel && !wr;
        cmd.rd_status  = sel && !wr && in_window && (reg_sel == REG_STATUS);
        cmd.wr_enable  = sel && wr && in_window && (reg_sel == REG_ENABLE);
        cmd.wr_disable = sel && wr && in_window && (reg_sel == REG_DISABLE);
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (cmd.rd_any) state_d = BUS_RESP;
            BUS_RESP: if (!cmd.rd_any) state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // read data capture
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (cmd.rd_any) begin
            if (!in_window) begin
                rdata_q <= '0;
            end else begin
                unique case (reg_sel)
                    REG_STATUS: rdata_q <= status_word;
                    REG_MASK:   rdata_q <= mask_word;
                    default:    rdata_q <= '0;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        rvalid = (state_q == BUS_RESP);
        rdata  = rvalid ? rdata_q : '0;
    end

endmodule

// File: rtl/flash_irq_unit.sv
module flash_irq_unit
    import irqu_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic [6:0]        evt_i,
    input  logic              ctrl_en_i,
    output logic              irq_o,
    output logic              cmd_done_o
);

    bus_cmd_t         cmd;
    logic [REG_W-1:0] flag_vec;
    logic [REG_W-1:0] mask_vec;
    logic [REG_W-1:0] evt_word;
    logic [REG_W-1:0] status_word;

    assign evt_word = evt_to_word(evt_i);

    always_comb begin
        status_word              = flag_vec;
        status_word[POS_ENLIVE]  = ctrl_en_i;
    end

    irqu_bus #(.ADDR_W(ADDR_W)) u_bus (
        .clk         (clk),
        .rst         (rst),
        .sel         (bus_sel),
        .wr          (bus_wr),
        .addr        (bus_addr),
        .status_word (status_word),
        .mask_word   (mask_vec),
        .cmd         (cmd),
        .rdata       (bus_rdata),
        .rvalid      (bus_rvalid)
    );

    irqu_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_word (evt_word),
        .clr_all  (cmd.rd_status),
        .flags_q  (flag_vec)
    );

    irqu_mask u_mask (
        .clk    (clk),
        .rst    (rst),
        .set_en (cmd.wr_enable),
        .clr_en (cmd.wr_disable),
        .wdata  (bus_wdata),
        .mask_q (mask_vec)
    );

    assign irq_o      = |(flag_vec & mask_vec);
    assign cmd_done_o = flag_vec[POS_INSTEND] & flag_vec[POS_CSRISE];

endmodule

// File: rtl/irqu_checker.sv
module irqu_checker #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              bus_rvalid,
    input logic [6:0]        evt_i,
    input logic              ctrl_en_i,
    input logic              irq_o,
    input logic [31:0]       flag_vec,
    input logic [31:0]       mask_vec
);

    logic rd_req, en_wr, dis_wr, st_rd;
    assign rd_req = bus_sel && !bus_wr;
    assign st_rd  = rd_req && (bus_addr == ADDR_W'(0));
    assign en_wr  = bus_sel && bus_wr && (bus_addr == ADDR_W'(4));
    assign dis_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(8));

    AST_RESET_CLEAN: assert property (@(posedge clk)
        rst |=> (flag_vec == 32'h0 && mask_vec == 32'h0 && !bus_rvalid)); // R1

    AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (rst)
        (|evt_i) |=> (flag_vec != 32'h0)); // R2

    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> bus_rvalid); // R3

    AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !bus_rvalid); // R3

    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (st_rd && evt_i == 7'h0) |=> (flag_vec == 32'h0)); // R3

    AST_LIVE_ENABLE: assert property (@(posedge clk) disable iff (rst)
        st_rd |=> (bus_rdata[24] == $past(ctrl_en_i))); // R5

    AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
        en_wr |=> ((mask_vec & $past(bus_wdata) & 32'h0000_070F)
                   == ($past(bus_wdata) & 32'h0000_070F))); // R6

    AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        dis_wr |=> ((mask_vec & $past(bus_wdata)) == 32'h0)); // R7

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(en_wr || dis_wr) |=> $stable(mask_vec)); // R8

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past((|evt_i) || en_wr)); // R9

endmodule

bind flash_irq_unit irqu_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .evt_i      (evt_i),
    .ctrl_en_i  (ctrl_en_i),
    .irq_o      (irq_o),
    .flag_vec   (flag_vec),
    .mask_vec   (mask_vec)
);

// File: tb/tb_flash_irq_unit.sv
`timescale 1ns/1ps
module tb_flash_irq_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel, bus_wr;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [6:0]  evt_i;
    logic        ctrl_en_i;
    logic        irq_o, cmd_done_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    flash_irq_unit #(.ADDR_W(4)) dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .evt_i(evt_i), .ctrl_en_i(ctrl_en_i),
        .irq_o(irq_o), .cmd_done_o(cmd_done_o)
    );

    // bench-side event layout: bits 0,1,2,3,8,9,10
    function automatic logic [31:0] spread(input logic [6:0] e);
        return {21'h0, e[6:4], 4'h0, e[3:0]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic bus_read_ev(input logic [3:0] a, input logic [6:0] ev, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a; evt_i = ev;
        @(negedge clk);
        bus_sel = 0; evt_i = '0;
        check(bus_rvalid === 1'b1, "R3 rvalid", {31'h0, bus_rvalid}, 32'h1);
        d = bus_rdata;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_read_ev(a, 7'h0, d);
    endtask

    task automatic pulse(input logic [6:0] ev);
        @(negedge clk);
        evt_i = ev;
        @(negedge clk);
        evt_i = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, exp;
        rst = 1; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
        evt_i = '0; ctrl_en_i = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        check(irq_o === 1'b0, "R1 irq", {31'h0, irq_o}, 0);
        check(cmd_done_o === 1'b0, "R1 done", {31'h0, cmd_done_o}, 0);
        check(bus_rvalid === 1'b0, "R1 rvalid", {31'h0, bus_rvalid}, 0);
        bus_read(4'h0, d); check(d === 32'h0, "R1 status", d, 0);
        bus_read(4'hC, d); check(d === 32'h0, "R1 mask", d, 0);

        // R2 each event alone, sticky, then R3 clear
        for (int k = 0; k < 7; k++) begin
            pulse(7'(1 << k));
            repeat (3) @(negedge clk);
            exp = spread(7'(1 << k));
            bus_read(4'h0, d); check(d === exp, "R2 sticky position", d, exp);
            bus_read(4'h0, d); check(d === 32'h0, "R3 cleared by read", d, 0);
        end

        // sweep of all mask subsets, R6 R7 R9 R3 R5
        for (int m = 0; m < 128; m++) begin
            logic [6:0] mm, ee, rem;
            logic en;
            mm = 7'(m); ee = 7'((m * 37 + 11) & 127); en = mm[0];
            ctrl_en_i = en;
            bus_write(4'h4, spread(mm) | 32'hFF00_00F0);
            bus_read(4'hC, d); check(d === spread(mm), "R6 mask set", d, spread(mm));
            pulse(ee);
            check(irq_o === |(mm & ee), "R9 irq level", {31'h0, irq_o}, {31'h0, |(mm & ee)});
            exp = spread(ee) | (32'(en) << 24);
            bus_read(4'h0, d); check(d === exp, "R3 status word", d, exp);
            bus_read(4'h0, d); check(d === (32'(en) << 24), "R5 live enable kept", d, 32'(en) << 24);
            check(irq_o === 1'b0, "R9 irq after clear", {31'h0, irq_o}, 0);
            rem = mm & ~7'h55;
            bus_write(4'h8, spread(7'h55));
            bus_read(4'hC, d); check(d === spread(rem), "R7 mask clear", d, spread(rem));
            bus_write(4'h8, 32'hFFFF_FFFF);
        end
        ctrl_en_i = 0;

        // R8 read-only and write-only locations
        bus_write(4'h0, 32'hFFFF_FFFF);
        bus_read(4'h0, d); check(d === 32'h0, "R8 status write ignored", d, 0);
        bus_write(4'hC, 32'hFFFF_FFFF);
        bus_read(4'hC, d); check(d === 32'h0, "R8 mask write ignored", d, 0);
        bus_write(4'h4, 32'h0000_0101);
        bus_read(4'h4, d); check(d === 32'h0, "R8 enable reads zero", d, 0);
        bus_read(4'h8, d); check(d === 32'h0, "R8 disable reads zero", d, 0);
        bus_read(4'hC, d); check(d === 32'h0000_0101, "R8 mask read", d, 32'h101);
        bus_write(4'h8, 32'hFFFF_FFFF);

        // R4 event during clearing read
        pulse(7'h20);
        bus_read_ev(4'h0, 7'h01, d); check(d === 32'h0000_0200, "R4 read excludes new", d, 32'h200);
        bus_read(4'h0, d); check(d === 32'h0000_0001, "R4 new event kept", d, 32'h1);

        // R10 completion in both orders
        pulse(7'h40);
        check(cmd_done_o === 1'b0, "R10 end only", {31'h0, cmd_done_o}, 0);
        pulse(7'h10);
        check(cmd_done_o === 1'b1, "R10 end then rise", {31'h0, cmd_done_o}, 1);
        bus_read(4'h0, d);
        check(cmd_done_o === 1'b0, "R10 cleared", {31'h0, cmd_done_o}, 0);
        pulse(7'h10);
        check(cmd_done_o === 1'b0, "R10 rise only", {31'h0, cmd_done_o}, 0);
        pulse(7'h40);
        check(cmd_done_o === 1'b1, "R10 rise then end", {31'h0, cmd_done_o}, 1);

        // R1 reset mid-run
        bus_write(4'h4, 32'hFFFF_FFFF);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        check(irq_o === 1'b0, "R1 irq after reset", {31'h0, irq_o}, 0);
        bus_read(4'hC, d); check(d === 32'h0, "R1 mask after reset", d, 0);
        bus_read(4'h0, d); check(d === 32'h0, "R1 flags after reset", d, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule